// File: doc/BRIEF.md
# Timer with Selectable Trigger Outputs

This block is an up/down timer that produces two trigger lines for other blocks on the chip, such as a converter that starts a conversion on each trigger. A prescaler divides the clock, and the main counter steps once per prescaler period between 0 and a reload limit. Each wrap is an update event, and so is a software request. Six compare channels compare the count against programmable thresholds. Each channel gives a reference level and a match pulse.

Configuration arrives through a single write port made of an address, a data word and a write strobe. A main selector (3 bits) and an auxiliary selector (4 bits) each pick the source that drives their trigger line. The auxiliary selector can also pick the upper compare channels and edge combinations of channel pairs. When the timer is stopped, the count freezes and both trigger lines stay low.

Top module: `trgsel_timer`

## Requirements
- R1: While running, the count advances once every (P+1) clocks and an update event occurs once every (P+1)*(L+1) clocks, where P is the active prescaler value and L is the active reload limit.
- R2: Counting up (control bit 1 = 0), the count goes from L to 0 with an update event. Counting down (control bit 1 = 1), the count goes from 0 to L with an update event.
- R3: With preload on (control bit 2 = 1), a new reload limit (address 1) takes effect only after the next update event. With preload off, it takes effect at once. A new prescaler value (address 0) always waits for the next update event.
- R4: A write to address 4 is a software update. At that edge it clears the prescaler and the count, copies the pending prescaler and reload values into the active ones, and raises an update event.
- R5: Main selector (address 3, bits 2:0): 0 gives a one-clock pulse after a software update; 1 gives the run level; 2 gives a one-clock pulse after any update event; 3 gives channel 1's match pulse; 4 to 7 give the reference levels of channels 1 to 4.
- R6: Auxiliary selector (address 3, bits 7:4): codes 0 to 7 give the same sources as the main codes; 8 and 9 give the reference levels of channels 5 and 6.
- R7: Auxiliary codes 10 and 11 give the match pulses of channel 4 and channel 6.
- R8: Auxiliary codes 12 to 15 give one-clock edge pulses, all taken from reference levels: 12 is a channel 4 rise OR a channel 6 rise, 13 is a channel 4 rise OR a channel 6 fall, 14 is a channel 5 rise OR a channel 6 rise, and 15 is a channel 5 rise OR a channel 6 fall.
- R9: The reference of channel k (threshold at address 7+k, k = 1..6) is high while count < threshold. Its match pulse is high for the one clock that follows a counter step that lands on the threshold.
- R10: After reset, and whenever the run bit (control address 2, bit 0) is 0, the count holds and both trigger lines are low. A software update still clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 4 | Write address: 0 prescaler, 1 reload, 2 control, 3 selectors, 4 software update, 8..13 thresholds |
| cfg_wdata | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| trig_main | output | 1 | Trigger line chosen by the main selector |
| trig_aux | output | 1 | Trigger line chosen by the auxiliary selector |

## Verification
A write takes effect at the clock edge that samples it. The count changes at that same edge. A level source is visible during the cycle after that edge. An update, software or match pulse is high for exactly the one cycle after the edge that caused it. An edge pulse is high during the cycle in which the reference first shows its new level. The bench advances its behavioural model at each rising edge with the same input values the design samples. It compares count and both trigger lines at the following falling edge, so every expected value lines up with the register stages above.

// File: rtl/trgsel_pkg.sv
package trgsel_pkg;

    localparam int NCH = 6;

    localparam logic [3:0] ADDR_PSC  = 4'd0;
    localparam logic [3:0] ADDR_ARR  = 4'd1;
    localparam logic [3:0] ADDR_CTRL = 4'd2;
    localparam logic [3:0] ADDR_SEL  = 4'd3;
    localparam logic [3:0] ADDR_EVT  = 4'd4;
    localparam logic [3:0] ADDR_CMP0 = 4'd8;

    typedef enum logic [3:0] {
        TS_SWUPD   = 4'd0,
        TS_ENABLE  = 4'd1,
        TS_UPDATE  = 4'd2,
        TS_MATCH1  = 4'd3,
        TS_LVL1    = 4'd4,
        TS_LVL2    = 4'd5,
        TS_LVL3    = 4'd6,
        TS_LVL4    = 4'd7,
        TS_LVL5    = 4'd8,
        TS_LVL6    = 4'd9,
        TS_MATCH4  = 4'd10,
        TS_MATCH6  = 4'd11,
        TS_E4R_6R  = 4'd12,
        TS_E4R_6F  = 4'd13,
        TS_E5R_6R  = 4'd14,
        TS_E5R_6F  = 4'd15
    } trig_sel_e;

    typedef struct packed {
        logic preload;
        logic down;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic            upd;
        logic            swu;
        logic            run;
        logic [NCH-1:0]  lvl;
        logic [NCH-1:0]  rise;
        logic [NCH-1:0]  fall;
        logic [NCH-1:0]  hit;
    } trig_src_t;

    function automatic logic pick_trig(trig_src_t s, trig_sel_e sel);
        logic r;
        case (sel)
            TS_SWUPD:  r = s.swu;
            TS_ENABLE: r = s.run;
            TS_UPDATE: r = s.upd;
            TS_MATCH1: r = s.hit[0];
            TS_LVL1:   r = s.lvl[0];
            TS_LVL2:   r = s.lvl[1];
            TS_LVL3:   r = s.lvl[2];
            TS_LVL4:   r = s.lvl[3];
            TS_LVL5:   r = s.lvl[4];
            TS_LVL6:   r = s.lvl[5];
            TS_MATCH4: r = s.hit[3];
            TS_MATCH6: r = s.hit[5];
            TS_E4R_6R: r = s.rise[3] | s.rise[5];
            TS_E4R_6F: r = s.rise[3] | s.fall[5];
            TS_E5R_6R: r = s.rise[4] | s.rise[5];
            default:   r = s.rise[4] | s.fall[5];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trgsel_prescaler.sv
module trgsel_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] pcnt_q;
    logic             at_end;

    assign at_end = (pcnt_q == limit);
    assign tick   = run & ~clr & at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/trgsel_counter.sv
module trgsel_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             down,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_edge;

    assign at_edge = down ? (cnt_q == '0) : (cnt_q == reload);
    assign wrap    = tick & ~clr & at_edge;

    always_comb begin
        count_nxt = cnt_q;
        if (clr) begin
            count_nxt = '0;
        end else if (tick) begin
            if (down) count_nxt = at_edge ? reload : cnt_q - 1'b1;
            else      count_nxt = at_edge ? '0     : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= count_nxt;
    end

    assign count = cnt_q;
endmodule

// File: rtl/trgsel_compare.sv
module trgsel_compare
    import trgsel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic [CNT_W-1:0]          count,
    input  logic [CNT_W-1:0]          count_nxt,
    input  logic [NCH-1:0][CNT_W-1:0] thresh,
    output logic [NCH-1:0]            lvl,
    output logic [NCH-1:0]            rise,
    output logic [NCH-1:0]            fall,
    output logic [NCH-1:0]            hit
);
    logic [NCH-1:0] lvl_prev_q;
    logic [NCH-1:0] hit_q;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign lvl[k] = (count < thresh[k]);

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_prev_q[k] <= 1'b0;
                hit_q[k]      <= 1'b0;
            end else begin
                lvl_prev_q[k] <= lvl[k];
                hit_q[k]      <= tick && (count_nxt == thresh[k]);
            end
        end
    end

    assign rise = lvl & ~lvl_prev_q;
    assign fall = ~lvl & lvl_prev_q;
    assign hit  = hit_q;
endmodule

// File: rtl/trgsel_select.sv
module trgsel_select
    import trgsel_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  trig_src_t        src,
    input  logic [SEL_W-1:0] sel,
    output logic             trig
);
    trig_sel_e code;

    if (SEL_W >= 4) begin : g_wide
        assign code = trig_sel_e'(sel[3:0]);
    end else begin : g_narrow
        assign code = trig_sel_e'({{(4-SEL_W){1'b0}}, sel});
    end

    assign trig = src.run & pick_trig(src, code);
endmodule

// File: rtl/trgsel_timer.sv
module trgsel_timer
    import trgsel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] count,
    output logic             trig_main,
    output logic             trig_aux
);
    localparam int MAIN_W = 3;
    localparam int AUX_W  = 4;

    logic [CNT_W-1:0]          psc_pend_q, psc_act_q;
    logic [CNT_W-1:0]          arr_pend_q, arr_act_q, arr_eff;
    ctrl_t                     ctrl_q;
    logic [MAIN_W-1:0]         main_sel_q;
    logic [AUX_W-1:0]          aux_sel_q;
    logic [NCH-1:0][CNT_W-1:0] thresh_q;
    logic                      upd_q, swu_q;

    logic                      swu, tick, wrap, uev;
    logic [CNT_W-1:0]          count_nxt;
    trig_src_t                 src;

    assign swu     = cfg_we && (cfg_addr == ADDR_EVT);
    assign arr_eff = ctrl_q.preload ? arr_act_q : arr_pend_q;
    assign uev     = swu | wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_pend_q <= '0;
            arr_pend_q <= '0;
            ctrl_q     <= '0;
            main_sel_q <= '0;
            aux_sel_q  <= '0;
            thresh_q   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_PSC:  psc_pend_q <= cfg_wdata;
                ADDR_ARR:  arr_pend_q <= cfg_wdata;
                ADDR_CTRL: ctrl_q     <= ctrl_t'(cfg_wdata[2:0]);
                ADDR_SEL: begin
                    main_sel_q <= cfg_wdata[MAIN_W-1:0];
                    aux_sel_q  <= cfg_wdata[4 +: AUX_W];
                end
                default: begin
                    for (int k = 0; k < NCH; k++) begin
                        if (cfg_addr == ADDR_CMP0 + 4'(k)) thresh_q[k] <= cfg_wdata;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_act_q <= '0;
            arr_act_q <= '0;
            upd_q     <= 1'b0;
            swu_q     <= 1'b0;
        end else begin
            if (uev) begin
                psc_act_q <= psc_pend_q;
                arr_act_q <= arr_pend_q;
            end
            upd_q <= uev;
            swu_q <= swu;
        end
    end

    trgsel_prescaler #(.CNT_W(CNT_W)) u_psc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.run),
        .clr   (swu),
        .limit (psc_act_q),
        .tick  (tick)
    );

    trgsel_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (swu),
        .tick      (tick),
        .down      (ctrl_q.down),
        .reload    (arr_eff),
        .count     (count),
        .count_nxt (count_nxt),
        .wrap      (wrap)
    );

    trgsel_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .count     (count),
        .count_nxt (count_nxt),
        .thresh    (thresh_q),
        .lvl       (src.lvl),
        .rise      (src.rise),
        .fall      (src.fall),
        .hit       (src.hit)
    );

    assign src.upd = upd_q;
    assign src.swu = swu_q;
    assign src.run = ctrl_q.run;

    trgsel_select #(.SEL_W(MAIN_W)) u_sel_main (
        .src  (src),
        .sel  (main_sel_q),
        .trig (trig_main)
    );

    trgsel_select #(.SEL_W(AUX_W)) u_sel_aux (
        .src  (src),
        .sel  (aux_sel_q),
        .trig (trig_aux)
    );
endmodule

// File: rtl/trgsel_timer_chk.sv
module trgsel_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [3:0]       cfg_addr,
    input logic [CNT_W-1:0] count,
    input logic             trig_main,
    input logic             trig_aux,
    input logic             run,
    input logic             down,
    input logic             tick,
    input logic [CNT_W-1:0] arr_eff,
    input logic [2:0]       main_sel,
    input logic [3:0]       aux_sel
);
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!trig_main && !trig_aux));  // R10

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !(cfg_we && cfg_addr == 4'd4)) |=> $stable(count));  // R10

    AST_SWU_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 4'd4) |=> (count == '0));  // R4

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && down && count == '0) |=> (count == $past(arr_eff)));  // R2

    AST_AUX_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (aux_sel < 4'd8 && aux_sel[2:0] == main_sel) |-> (trig_aux == trig_main));  // R6

    AST_ENABLE_LVL: assert property (@(posedge clk) disable iff (rst)
        (main_sel == 3'd1) |-> (trig_main == run));  // R5
endmodule

bind trgsel_timer trgsel_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .count     (count),
    .trig_main (trig_main),
    .trig_aux  (trig_aux),
    .run       (ctrl_q.run),
    .down      (ctrl_q.down),
    .tick      (tick),
    .arr_eff   (arr_eff),
    .main_sel  (main_sel_q),
    .aux_sel   (aux_sel_q)
);

// File: tb/trgsel_timer_tb_top.sv
module trgsel_timer_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic [W-1:0] count;
    logic         trig_main, trig_aux;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_on   = 1'b0;
    bit    done     = 1'b0;
    string tag      = "R10";

    always #4 clk = ~clk;

    trgsel_timer #(.CNT_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .count     (count),
        .trig_main (trig_main),
        .trig_aux  (trig_aux)
    );

    // behavioural reference model
    logic [W-1:0] m_psc_p, m_psc_a, m_arr_p, m_arr_a, m_pcnt, m_cnt;
    logic [W-1:0] m_thr [6];
    bit           m_run, m_down, m_pre, m_upd, m_swu;
    bit   [2:0]   m_msel;
    bit   [3:0]   m_asel;
    bit           m_hit [6];
    bit           m_lprev [6];

    always @(posedge clk) begin
        logic [W-1:0] ae, nc;
        bit ug, tk, wr;
        if (rst) begin
            m_psc_p = 0; m_psc_a = 0; m_arr_p = 0; m_arr_a = 0;
            m_pcnt = 0; m_cnt = 0; m_run = 0; m_down = 0; m_pre = 0;
            m_upd = 0; m_swu = 0; m_msel = 0; m_asel = 0;
            for (int k = 0; k < 6; k++) begin
                m_thr[k] = 0; m_hit[k] = 0; m_lprev[k] = 0;
            end
        end else begin
            ug = cfg_we && cfg_addr == 4'd4;
            ae = m_pre ? m_arr_a : m_arr_p;
            tk = m_run && !ug && (m_pcnt == m_psc_a);
            nc = m_cnt;
            wr = 0;
            if (ug) nc = 0;
            else if (tk) begin
                if (m_down) begin
                    if (m_cnt == 0) begin nc = ae; wr = 1; end
                    else nc = m_cnt - 1;
                end else begin
                    if (m_cnt == ae) begin nc = 0; wr = 1; end
                    else nc = m_cnt + 1;
                end
            end
            for (int k = 0; k < 6; k++) begin
                m_lprev[k] = (m_cnt < m_thr[k]);
                m_hit[k]   = tk && (nc == m_thr[k]);
            end
            if (ug) m_pcnt = 0;
            else if (m_run) m_pcnt = (m_pcnt == m_psc_a) ? 0 : m_pcnt + 1;
            if (ug || wr) begin m_psc_a = m_psc_p; m_arr_a = m_arr_p; end
            m_upd = ug || wr;
            m_swu = ug;
            m_cnt = nc;
            if (cfg_we) begin
                case (cfg_addr)
                    4'd0: m_psc_p = cfg_wdata;
                    4'd1: m_arr_p = cfg_wdata;
                    4'd2: begin m_run = cfg_wdata[0]; m_down = cfg_wdata[1]; m_pre = cfg_wdata[2]; end
                    4'd3: begin m_msel = cfg_wdata[2:0]; m_asel = cfg_wdata[7:4]; end
                    default: if (cfg_addr >= 8 && cfg_addr <= 13) m_thr[cfg_addr-8] = cfg_wdata;
                endcase
            end
        end
    end

    function automatic bit lvl(int k);
        return m_cnt < m_thr[k];
    endfunction
    function automatic bit rs(int k);
        return lvl(k) && !m_lprev[k];
    endfunction
    function automatic bit fl(int k);
        return !lvl(k) && m_lprev[k];
    endfunction

    function automatic bit exp_src(bit [3:0] s);
        case (s)
            0: return m_swu;
            1: return 1'b1;
            2: return m_upd;
            3: return m_hit[0];
            4, 5, 6, 7, 8, 9: return lvl(int'(s) - 4);
            10: return m_hit[3];
            11: return m_hit[5];
            12: return rs(3) || rs(5);
            13: return rs(3) || fl(5);
            14: return rs(4) || rs(5);
            default: return rs(4) || fl(5);
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(tag, "count", int'(count), int'(m_cnt));
            check(tag, "trig_main", int'(trig_main), int'(m_run && exp_src({1'b0, m_msel})));
            check(tag, "trig_aux", int'(trig_aux), int'(m_run && exp_src(m_asel)));
        end
    end

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int pulses;
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10", "reset count", int'(count), 0);
        check("R10", "reset trig_main", int'(trig_main), 0);
        check("R10", "reset trig_aux", int'(trig_aux), 0);
        cmp_on = 1'b1;

        // R1 / R2: up counting, update pulse rate
        tag = "R1";
        wr(4'd0, 2);
        wr(4'd1, 3);
        wr(4'd3, 8'h22);
        wr(4'd2, 1);
        wr(4'd4, 0);
        idle(2);
        pulses = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (trig_main) pulses++;
        end
        check("R1", "update pulses in 120 clocks", pulses, 10);
        tag = "R2";
        idle(30);

        // R2: down counting
        wr(4'd2, 3);
        idle(60);

        // R3: reload preload on, then off; prescaler buffered
        tag = "R3";
        wr(4'd0, 0);
        wr(4'd1, 9);
        wr(4'd2, 5);
        wr(4'd4, 0);
        idle(3);
        wr(4'd1, 4);
        idle(40);
        wr(4'd2, 1);
        wr(4'd1, 7);
        idle(30);
        wr(4'd0, 1);
        idle(30);

        // R4: software update mid-run
        tag = "R4";
        wr(4'd0, 0);
        wr(4'd1, 9);
        idle(5);
        wr(4'd4, 0);
        check("R4", "count after software update", int'(count), 0);
        idle(10);

        // R5..R9: trigger source selection
        for (int k = 0; k < 6; k++) wr(4'(8 + k), k + 2);
        for (int s = 0; s < 8; s++) begin
            tag = (s >= 3) ? "R9" : "R5";
            wr(4'd3, s);
            idle(12);
            wr(4'd4, 0);
            idle(18);
        end
        for (int s = 0; s < 16; s++) begin
            tag = (s < 10) ? "R6" : ((s < 12) ? "R7" : "R8");
            wr(4'd3, s << 4);
            idle(12);
            wr(4'd4, 0);
            idle(18);
        end
        wr(4'd2, 3);
        for (int s = 10; s < 16; s++) begin
            tag = (s < 12) ? "R7" : "R8";
            wr(4'd3, s << 4);
            idle(25);
        end

        // R10: stop holds count, outputs idle
        tag = "R10";
        wr(4'd3, 8'h21);
        wr(4'd2, 0);
        held = count;
        idle(20);
        check("R10", "held count", int'(count), int'(held));
        check("R10", "trig_main stopped", int'(trig_main), 0);
        check("R10", "trig_aux stopped", int'(trig_aux), 0);
        wr(4'd4, 0);
        check("R10", "count cleared while stopped", int'(count), 0);
        idle(5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule